// File: doc/BRIEF.md
# Boundary-Scan Cell Chain with Pin Control

This block holds the boundary-scan cells for a configurable set of input pins and output pins. A TAP controller and an instruction decoder sit outside it and supply a mode code, capture/shift/update strobes, TCK and TDI. The block decides which data register, the boundary chain or a one-bit bypass stage, sits between TDI and TDO. It also decides where each output pad gets its value and its enable: from the core logic, from the update latches, or forced off.

The chain has one cell per input pin and two cells per output pin. For each output pin the data cell sits nearer TDI and the enable cell sits nearer TDO. Capture and shift act on the rising edge of TCK. The update latches load on the falling edge, so a value that has been shifted in reaches the pads half a cycle after the update strobe is sampled.

Top module: `bscan_chain`

## Requirements
- R1: The chain has N_IN + 2*N_OUT cells, indexed from 0 at the TDO end. Input pin j is cell j. Output pin k uses cell N_IN+2k for its enable and cell N_IN+2k+1 for its data, so the data cell lies nearer TDI.
- R2: When the chain is selected, a rising TCK edge with capture_dr high loads pad_in into the input cells and core_out/core_oe into the output data/enable cells. Capture takes precedence over shift.
- R3: When the chain is selected, each rising TCK edge with shift_dr high moves every cell one place toward TDO and loads tdi into the top cell. tdo shows cell 0 whenever the chain is selected.
- R4: The chain is selected for mode 1 (sample/preload) and mode 2 (external test). Only while it is selected does a falling TCK edge with update_dr high copy the output cells into the update latches. At all other times the latches hold their value.
- R5: In mode 0, in mode 1 and in the unused codes 5 to 7, pad_out equals core_out and pad_oe equals core_oe. In these modes the update latches have no effect on the pads.
- R6: In mode 2 each pad_out and pad_oe is driven from the update latch of that pin's data cell and enable cell.
- R7: In mode 3 (clamp) the pads are driven from the update latches, and the bypass stage, not the chain, sits between TDI and TDO.
- R8: In mode 4 (high impedance) every pad_oe is 0 and every pad_out is 0, and the bypass stage is selected.
- R9: Whenever the chain is not selected, the bypass stage loads 0 on capture and loads tdi on shift, and tdo shows that stage. This gives a one-cycle delay from tdi to tdo.
- R10: When trst_n is low at a TCK edge, the chain cells, the bypass stage and the update latches clear to 0. In modes 2 and 3, reset therefore leaves the pads at value 0 and disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Decoded instruction: 0 other, 1 sample/preload, 2 external test, 3 clamp, 4 high impedance |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data in |
| core_out | input | N_OUT | Output values from the core |
| core_oe | input | N_OUT | Output enables from the core |
| pad_in | input | N_IN | Values seen at the input pads |
| tdo | output | 1 | Serial data out of the selected register |
| pad_out | output | N_OUT | Value driven to the output pads |
| pad_oe | output | N_OUT | Enable for the output pads |

## Verification
The assertions assume that the strobes and the mode change only between rising TCK edges and stay steady across the falling edge, as a TAP controller guarantees. The stall checks on the latches assume that update_dr has been low for the whole preceding cycle. The bench drives every input two nanoseconds after each rising edge, never raises more than one strobe at a time, and changes mode only while all strobes are low. This keeps the stimulus inside those assumptions.

// File: rtl/bscan_pkg.sv
// Package: shared mode codes and the control word derived from them.
// Assumes codes 5..7 behave like code 0.
package bscan_pkg;

    typedef enum logic [2:0] {
        MODE_OTHER  = 3'd0,
        MODE_SAMPLE = 3'd1,
        MODE_EXTEST = 3'd2,
        MODE_CLAMP  = 3'd3,
        MODE_HIGHZ  = 3'd4
    } bs_mode_e;

    typedef struct packed {
        logic chain_sel;  // boundary chain is the data register
        logic pin_latch;  // pads come from update latches
        logic pin_off;    // pads forced off
    } bs_ctrl_t;

    // Turn a mode code into the control word.
    function automatic bs_ctrl_t decode_mode(input logic [2:0] code);
        bs_ctrl_t c;
        c = '0;
        case (code)
            MODE_SAMPLE: c.chain_sel = 1'b1;
            MODE_EXTEST: begin c.chain_sel = 1'b1; c.pin_latch = 1'b1; end
            MODE_CLAMP:  c.pin_latch = 1'b1;
            MODE_HIGHZ:  c.pin_off = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bscan_cells.sv
// Module: shift stages of the boundary chain plus the update latches of the
// output-pin cells. Assumes strobes are stable around both TCK edges.
module bscan_cells #(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2,
    localparam int LEN  = N_IN + 2 * N_OUT
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 sel,
    input  logic                 capture_dr,
    input  logic                 shift_dr,
    input  logic                 update_dr,
    input  logic                 tdi,
    input  logic [LEN-1:0]       cap_vec,
    output logic [LEN-1:0]       shift_q,
    output logic [2*N_OUT-1:0]   upd_q
);

    // Capture parallel values or shift toward TDO on the rising edge.
    always_ff @(posedge tck) begin
        if (!trst_n)
            shift_q <= '0;
        else if (sel && capture_dr)
            shift_q <= cap_vec;
        else if (sel && shift_dr)
            shift_q <= {tdi, shift_q[LEN-1:1]};
    end

    // Copy the output-pin cells into the update latches on the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n)
            upd_q <= '0;
        else if (sel && update_dr)
            upd_q <= shift_q[LEN-1:N_IN];
    end

endmodule

// File: rtl/bscan_bypass.sv
// Module: one-bit bypass stage used whenever the chain is not selected.
module bscan_bypass (
    input  logic tck,
    input  logic trst_n,
    input  logic sel,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic tdi,
    output logic byp_q
);

    // Load zero on capture and tdi on shift.
    always_ff @(posedge tck) begin
        if (!trst_n)
            byp_q <= 1'b0;
        else if (sel && capture_dr)
            byp_q <= 1'b0;
        else if (sel && shift_dr)
            byp_q <= tdi;
    end

endmodule

// File: rtl/bscan_pinmux.sv
// Module: per-pin selection of pad value and enable among core, latch, off.
// Assumes latch vector ordered enable at even, data at odd positions.
module bscan_pinmux
    import bscan_pkg::*;
#(
    parameter int N_OUT = 2
) (
    input  bs_ctrl_t             ctrl,
    input  logic [N_OUT-1:0]     core_out,
    input  logic [N_OUT-1:0]     core_oe,
    input  logic [2*N_OUT-1:0]   upd_q,
    output logic [N_OUT-1:0]     pad_out,
    output logic [N_OUT-1:0]     pad_oe
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_pin
        // Pick the source for pin k.
        always_comb begin
            if (ctrl.pin_off) begin
                pad_out[k] = 1'b0;
                pad_oe[k]  = 1'b0;
            end else if (ctrl.pin_latch) begin
                pad_out[k] = upd_q[2*k+1];
                pad_oe[k]  = upd_q[2*k];
            end else begin
                pad_out[k] = core_out[k];
                pad_oe[k]  = core_oe[k];
            end
        end
    end

endmodule

// File: rtl/bscan_chain.sv
// Module: top of the boundary-scan chain. Selects chain or bypass, builds the
// capture vector and drives the pads. TAP and instruction decode are external.
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic [2:0]         mode,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    input  logic [N_OUT-1:0]   core_out,
    input  logic [N_OUT-1:0]   core_oe,
    input  logic [N_IN-1:0]    pad_in,
    output logic               tdo,
    output logic [N_OUT-1:0]   pad_out,
    output logic [N_OUT-1:0]   pad_oe
);

    localparam int LEN = N_IN + 2 * N_OUT;

    bs_ctrl_t           ctrl;
    logic [LEN-1:0]     cap_vec;
    logic [LEN-1:0]     shift_q;
    logic [2*N_OUT-1:0] upd_q;
    logic               byp_q;
    logic               chain_sel;

    // Decode the mode into selection controls.
    always_comb ctrl = decode_mode(mode);
    assign chain_sel = ctrl.chain_sel;

    // Input cells sit at the TDO end.
    for (genvar j = 0; j < N_IN; j++) begin : g_in
        assign cap_vec[j] = pad_in[j];
    end
    // Each output pin: enable cell, then data cell nearer TDI.
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        assign cap_vec[N_IN+2*k]   = core_oe[k];
        assign cap_vec[N_IN+2*k+1] = core_out[k];
    end

    bscan_cells #(.N_IN(N_IN), .N_OUT(N_OUT)) u_cells (
        .tck(tck), .trst_n(trst_n), .sel(chain_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .cap_vec(cap_vec), .shift_q(shift_q), .upd_q(upd_q)
    );

    bscan_bypass u_byp (
        .tck(tck), .trst_n(trst_n), .sel(!chain_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr),
        .tdi(tdi), .byp_q(byp_q)
    );

    bscan_pinmux #(.N_OUT(N_OUT)) u_mux (
        .ctrl(ctrl), .core_out(core_out), .core_oe(core_oe),
        .upd_q(upd_q), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Serial output from whichever register is selected.
    assign tdo = chain_sel ? shift_q[0] : byp_q;

endmodule

// File: rtl/bscan_chain_chk.sv
// Checker: temporal properties of bscan_chain, attached by bind.
// Assumes strobes and mode change only between rising TCK edges.
module bscan_chain_chk #(
    parameter int N_OUT = 2
) (
    input logic             tck,
    input logic             trst_n,
    input logic [2:0]       mode,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic             tdi,
    input logic             tdo,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OUT-1:0] core_oe,
    input logic [N_OUT-1:0] pad_out,
    input logic [N_OUT-1:0] pad_oe,
    input logic             cell1,
    input logic             chain_sel
);

    logic follow_core;
    assign follow_core = !(mode == 3'd2 || mode == 3'd3 || mode == 3'd4);

    AST_SHIFT_TOWARD_TDO: assert property (@(posedge tck) disable iff (!trst_n)
        (chain_sel && shift_dr && !capture_dr) ##1 chain_sel |-> tdo == $past(cell1)); // R3

    AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == 3'd2 && $past(mode) == 3'd2 && $past(trst_n) && !update_dr)
        |-> ($stable(pad_out) && $stable(pad_oe))); // R4

    AST_PADS_FOLLOW_CORE: assert property (@(posedge tck) disable iff (!trst_n)
        follow_core |-> (pad_out == core_out && pad_oe == core_oe)); // R5

    AST_HIGHZ_ALL_OFF: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == 3'd4) |-> (pad_oe == '0 && pad_out == '0)); // R8

    AST_BYPASS_DELAY: assert property (@(posedge tck) disable iff (!trst_n)
        (!chain_sel && shift_dr) ##1 !chain_sel |-> tdo == $past(tdi)); // R9

endmodule

bind bscan_chain bscan_chain_chk #(.N_OUT(N_OUT)) u_chk (
    .tck(tck), .trst_n(trst_n), .mode(mode), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .cell1(shift_q[1]), .chain_sel(chain_sel)
);

// File: tb/bscan_chain_test.sv
// Bench: scoreboard of serial-out bits plus direct pad checks.
module bscan_chain_test;

    localparam int N_IN  = 3;
    localparam int N_OUT = 2;
    localparam int LEN   = N_IN + 2 * N_OUT;

    logic             tck = 1'b0;
    logic             trst_n = 1'b0;
    logic [2:0]       mode = 3'd0;
    logic             capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic [N_OUT-1:0] core_out = '0, core_oe = '0;
    logic [N_IN-1:0]  pad_in = '0;
    logic             tdo;
    logic [N_OUT-1:0] pad_out, pad_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct { logic val; string req; } exp_t;
    exp_t sb_q[$];

    always #10 tck = ~tck;  // 50 MHz

    bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) uut (
        .tck(tck), .trst_n(trst_n), .mode(mode), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .tdo(tdo), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic tick();
        @(posedge tck); #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected chain contents after a capture (R1 layout, R2 sources).
    function automatic logic [LEN-1:0] cap_model();
        logic [LEN-1:0] v;
        for (int j = 0; j < N_IN; j++) v[j] = pad_in[j];
        for (int k = 0; k < N_OUT; k++) begin
            v[N_IN+2*k]   = core_oe[k];
            v[N_IN+2*k+1] = core_out[k];
        end
        return v;
    endfunction

    // Driver: capture, shift LEN bits, optional update; pushes expected tdo.
    task automatic scan(input logic [LEN-1:0] shin, input bit chain, input bit upd,
                        input string req);
        logic [LEN-1:0] cap;
        cap = cap_model();
        capture_dr = 1'b1; tick(); capture_dr = 1'b0;
        shift_dr = 1'b1;
        for (int i = 0; i < LEN; i++) begin
            exp_t e;
            tdi   = shin[i];
            e.req = req;
            if (chain) e.val = cap[i];
            else       e.val = (i == 0) ? 1'b0 : shin[i-1];
            sb_q.push_back(e);
            tick();
        end
        shift_dr = 1'b0;
        if (upd) begin update_dr = 1'b1; tick(); update_dr = 1'b0; end
        tick();
    endtask

    // Monitor: compare tdo with the queue during each shift cycle.
    always @(negedge tck) begin
        #4;
        if (shift_dr && trst_n) begin
            if (sb_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R3 actual=%b expected=<none>", tdo);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, {7'd0, tdo}, {7'd0, e.val});
            end
        end
    end

    // Expected pad values from a shifted-in vector (R1 positions).
    function automatic logic [2*N_OUT-1:0] latch_model(input logic [LEN-1:0] v);
        logic [2*N_OUT-1:0] r;
        for (int k = 0; k < N_OUT; k++) begin
            r[2*k+1] = v[N_IN+2*k+1];
            r[2*k]   = v[N_IN+2*k];
        end
        return r;
    endfunction

    task automatic check_pads(input string req, input logic [N_OUT-1:0] eo,
                              input logic [N_OUT-1:0] ee);
        @(negedge tck); #4;
        check({req, " pad_out"}, 8'(pad_out), 8'(eo));
        check({req, " pad_oe"},  8'(pad_oe),  8'(ee));
    endtask

    task automatic check_latched(input string req, input logic [LEN-1:0] v);
        logic [2*N_OUT-1:0] m;
        logic [N_OUT-1:0] eo, ee;
        m = latch_model(v);
        for (int k = 0; k < N_OUT; k++) begin eo[k] = m[2*k+1]; ee[k] = m[2*k]; end
        check_pads(req, eo, ee);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [LEN-1:0] V_A = 7'b1100110;
    localparam logic [LEN-1:0] V_B = 7'b0111001;
    localparam logic [LEN-1:0] V_C = 7'b1011011;

    initial begin
        core_out = 2'b10; core_oe = 2'b11;
        repeat (3) tick();
        trst_n = 1'b1;
        tick();
        // R10 / R5: reset state, pads follow core
        @(negedge tck); #4;
        check("R10 tdo after reset", {7'd0, tdo}, 8'd0);
        check_pads("R5 reset", 2'b10, 2'b11);

        // R1 R2 R3: sample mode capture and shift, then preload via update
        mode = 3'd1; pad_in = 3'b101; core_out = 2'b01; core_oe = 2'b10;
        scan(V_A, 1'b1, 1'b1, "R1 R2 R3 sample capture");
        check_pads("R5 sample ignores latches", 2'b01, 2'b10);

        // R6 R4: external test drives pads from preloaded latches
        mode = 3'd2; tick();
        check_latched("R6 R4 extest preload", V_A);

        // R2 R3 R6: new capture pattern in external test, new update
        pad_in = 3'b010; core_out = 2'b11; core_oe = 2'b00;
        scan(V_B, 1'b1, 1'b1, "R2 R3 extest capture");
        check_latched("R6 extest update", V_B);

        // R7 R9 R4: clamp keeps latched pads, bypass in the path, update ignored
        mode = 3'd3; tick();
        check_latched("R7 clamp pads", V_B);
        scan(V_C, 1'b0, 1'b1, "R9 R7 clamp bypass");
        check_latched("R4 clamp update ignored", V_B);

        // R8 R9: high impedance
        mode = 3'd4; tick();
        check_pads("R8 highz", 2'b00, 2'b00);
        scan(V_A, 1'b0, 1'b0, "R9 R8 highz bypass");

        // R6 R4: latches unchanged by the clamp and high-impedance scans
        mode = 3'd2; tick();
        check_latched("R4 latches kept", V_B);

        // R10: reset in external test clears latches
        trst_n = 1'b0; tick(); tick(); trst_n = 1'b1; tick();
        check_pads("R10 reset latches", 2'b00, 2'b00);

        // R5: unused code behaves like other
        mode = 3'd6; core_out = 2'b10; core_oe = 2'b01; tick();
        check_pads("R5 unused code", 2'b10, 2'b01);

        tick();
        if (sb_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R3 actual=%0d leftover expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule